// File: doc/BRIEF.md
# DMA Read/Write Bus Cycle Sequencer

This block is the bus engine of a byte-wide DMA master. A start pulse launches a sequential transfer. For every byte it runs one read cycle on the source port and then, right after it, one write cycle on the destination port. Each port is either memory or I/O. Each has its own start address and its own increment enable. The source and destination types, the increment enables and the wait-enable are captured when the start pulse is accepted. After that the block runs until the byte count is used up.

Memory cycles take three clocks: T1, T2 and T3. I/O cycles take four, because an automatic wait state (TW) sits between T2 and T3. An optional active-low wait input can add extra wait states. It is sampled on the clock edge that ends T2 for a memory cycle, or ends TW for an I/O cycle, and it is sampled again in every added state. The byte read from the source is captured as the read cycle ends. It is driven onto the outgoing data bus for the whole write cycle that follows.

Top module: `dma_cycle_seq`

## Requirements
- R1: A memory cycle lasts exactly three clocks (T1, T2, T3) when no wait state is added, and the memory request output is high in all three.
- R2: An I/O cycle lasts exactly four clocks (T1, T2, TW, T3) when no wait state is added, and the I/O request output is high in all four. The two request outputs are never high together.
- R3: In T1 neither strobe is active. rd_o is high from T2 to the end of a read cycle, and wr_o is high from T2 to the end of a write cycle. rd_o and wr_o are never high together.
- R4: With wait_en_i=1 at start, a low wait_ni on the edge that ends T2 (memory) or TW (I/O) adds one clock. wait_ni is sampled again at the end of each added clock, so N consecutive low samples add exactly N clocks.
- R5: With wait_en_i=0 at start, wait_ni has no effect and every cycle has its fixed length.
- R6: The byte on rd_data_i is captured on the edge that ends the read T3. data_oe_o is high and data_o holds that byte from the write T1 through the write T3.
- R7: Each transfer is a read at the current source address, followed immediately by a write at the current destination address. src_io_i/dst_io_i = 1 selects I/O and 0 selects memory. addr_o is stable through each cycle. The pair repeats count_i times.
- R8: After each transfer, the source and destination addresses each increase by one if their increment enable was 1 at start. Otherwise they stay the same.
- R9: busy_o is high from the clock after an accepted start until the last write T3 ends. done_o is then high for exactly one clock, with busy_o low.
- R10: A start pulse while busy_o is high is ignored. A start with count_i=0 runs no bus cycle and gives done_o in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| src_io_i | input | 1 | Source type, 1 = I/O, 0 = memory |
| dst_io_i | input | 1 | Destination type, 1 = I/O, 0 = memory |
| src_addr_i | input | AW | Source start address |
| dst_addr_i | input | AW | Destination start address |
| src_inc_i | input | 1 | Increment source address per transfer |
| dst_inc_i | input | 1 | Increment destination address per transfer |
| count_i | input | CW | Number of bytes to move |
| wait_en_i | input | 1 | Enable wait input sampling |
| wait_ni | input | 1 | Wait request, active low |
| rd_data_i | input | DW | Data bus input during reads |
| addr_o | output | AW | Address bus |
| mem_req_o | output | 1 | Memory request strobe |
| io_req_o | output | 1 | I/O request strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| data_o | output | DW | Write data |
| data_oe_o | output | 1 | Write data driver enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that wait_ni is a clean, clock-synchronous level and that the configuration inputs matter only on the clock where a start is accepted. They also assume the per-cycle type stays constant between T2 and TW. The stimulus changes every input only on the falling clock edge. It drives wait_ni low only for a counted number of clocks, aligned to the sample point of the running cycle, so each expected cycle length is known in advance. It changes the configuration inputs during a busy run only to show that a rejected start has no effect.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_TX   = 3'd4,
    TS_T3   = 3'd5
  } tstate_e;

  typedef enum logic {
    PH_RD = 1'b0,
    PH_WR = 1'b1
  } phase_e;
endpackage

// File: rtl/dma_tstate_fsm.sv
module dma_tstate_fsm
  import dma_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_i,
  input  logic    is_io_i,
  input  logic    wait_en_i,
  input  logic    wait_ni,
  output tstate_e ts_o
);
  tstate_e ts_q, ts_d;
  logic    stretch;

  assign stretch = wait_en_i && !wait_ni;

  always_comb begin
    ts_d = ts_q;
    unique case (ts_q)
      TS_IDLE: ts_d = go_i ? TS_T1 : TS_IDLE;
      TS_T1:   ts_d = TS_T2;
      TS_T2:   ts_d = is_io_i ? TS_TW : (stretch ? TS_TX : TS_T3);
      TS_TW:   ts_d = stretch ? TS_TX : TS_T3;
      TS_TX:   ts_d = stretch ? TS_TX : TS_T3;
      TS_T3:   ts_d = go_i ? TS_T1 : TS_IDLE;
      default: ts_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= TS_IDLE;
    else         ts_q <= ts_d;
  end

  assign ts_o = ts_q;

  p_io_tw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_q == TS_T2 && is_io_i) |=> (ts_q == TS_TW));
  p_tx_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_q == TS_TX) |-> $past(!wait_ni));
  p_no_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_q == TS_TX) |-> wait_en_i);
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (step_i) addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_rd_hold.sv
module dma_rd_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (cap_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          src_io_i,
  input  logic          dst_io_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          src_inc_i,
  input  logic          dst_inc_i,
  input  logic [CW-1:0] count_i,
  input  logic          wait_en_i,
  input  logic          wait_ni,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          mem_req_o,
  output logic          io_req_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int NPORT = 2;

  tstate_e       ts;
  phase_e        phase_q;
  logic [CW-1:0] rem_q;
  logic          src_io_q, dst_io_q, src_inc_q, dst_inc_q, wait_en_q;
  logic          done_q;
  logic          idle, accept, zero_len, in_t3, xfer_end, last_xfer, go, cur_io, strobe_ph;
  logic [AW-1:0] port_addr [NPORT];
  logic [AW-1:0] port_load [NPORT];
  logic          port_step [NPORT];

  assign idle      = (ts == TS_IDLE);
  assign accept    = idle && start_i;
  assign zero_len  = (count_i == '0);
  assign in_t3     = (ts == TS_T3);
  assign xfer_end  = in_t3 && (phase_q == PH_WR);
  assign last_xfer = (rem_q == CW'(1));
  assign go        = (accept && !zero_len) || (in_t3 && !(xfer_end && last_xfer));
  assign cur_io    = (phase_q == PH_WR) ? dst_io_q : src_io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_RD;
      rem_q     <= '0;
      src_io_q  <= 1'b0;
      dst_io_q  <= 1'b0;
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      wait_en_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= (accept && zero_len) || (xfer_end && last_xfer);
      if (accept) begin
        phase_q   <= PH_RD;
        rem_q     <= count_i;
        src_io_q  <= src_io_i;
        dst_io_q  <= dst_io_i;
        src_inc_q <= src_inc_i;
        dst_inc_q <= dst_inc_i;
        wait_en_q <= wait_en_i;
      end else if (in_t3) begin
        phase_q <= (phase_q == PH_RD) ? PH_WR : PH_RD;
        if (phase_q == PH_WR) rem_q <= rem_q - CW'(1);
      end
    end
  end

  dma_tstate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .is_io_i   (cur_io),
    .wait_en_i (wait_en_q),
    .wait_ni   (wait_ni),
    .ts_o      (ts)
  );

  assign port_load[0] = src_addr_i;
  assign port_load[1] = dst_addr_i;
  assign port_step[0] = xfer_end && src_inc_q;
  assign port_step[1] = xfer_end && dst_inc_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dma_addr_ctr #(.AW(AW)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (accept),
      .load_val_i (port_load[p]),
      .step_i     (port_step[p]),
      .addr_o     (port_addr[p])
    );
  end

  dma_rd_hold #(.DW(DW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (in_t3 && (phase_q == PH_RD)),
    .d_i    (rd_data_i),
    .q_o    (data_o)
  );

  assign strobe_ph = (ts == TS_T2) || (ts == TS_TW) || (ts == TS_TX) || in_t3;
  assign addr_o    = (phase_q == PH_WR) ? port_addr[1] : port_addr[0];
  assign mem_req_o = !idle && !cur_io;
  assign io_req_o  = !idle && cur_io;
  assign rd_o      = strobe_ph && (phase_q == PH_RD);
  assign wr_o      = strobe_ph && (phase_q == PH_WR);
  assign data_oe_o = !idle && (phase_q == PH_WR);
  assign busy_o    = !idle;
  assign done_o    = done_q;

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_req_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, io_req_o}));
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && $past(rd_o || wr_o) && $past(rd_o) == rd_o) |-> $stable(addr_o));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb;
  localparam int AW = 16, DW = 8, CW = 16;

  typedef struct {
    bit            io;
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            len;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, src_io_i = 1'b0, dst_io_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic src_inc_i = 1'b0, dst_inc_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic wait_en_i = 1'b0, wait_ni = 1'b1;
  logic [DW-1:0] rd_data_i;
  logic [AW-1:0] addr_o;
  logic mem_req_o, io_req_o, rd_o, wr_o, data_oe_o, busy_o, done_o;
  logic [DW-1:0] data_o;

  int errors = 0, checks = 0, cycles = 0, done_cnt = 0;
  item_t q[$];
  int wlen = 0;

  always #10 clk = ~clk;

  assign rd_data_i = addr_o[7:0] ^ 8'hA5;

  dma_cycle_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .src_io_i(src_io_i), .dst_io_i(dst_io_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .src_inc_i(src_inc_i), .dst_inc_i(dst_inc_i),
    .count_i(count_i), .wait_en_i(wait_en_i), .wait_ni(wait_ni), .rd_data_i(rd_data_i),
    .addr_o(addr_o), .mem_req_o(mem_req_o), .io_req_o(io_req_o), .rd_o(rd_o), .wr_o(wr_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // monitor and wait driver
  bit in_cyc = 0, c_io, c_wr, c_addr_bad, c_data_bad, prev_strobe = 0;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  int c_len, skip = 0, wcnt = 0;

  task automatic finish_cyc();
    item_t e;
    in_cyc = 0;
    chk(q.size() != 0, "R7 unexpected bus cycle", 0, 1);
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(c_io == e.io, "R7 cycle type", c_io, e.io);
    chk(c_wr == e.wr, "R7 read/write order", c_wr, e.wr);
    chk(c_addr == e.addr, "R8 cycle address", c_addr, e.addr);
    chk(!c_addr_bad, "R7 address stable", c_addr_bad, 0);
    chk(c_len == e.len, e.io ? "R2/R4/R5 I/O cycle length" : "R1/R4/R5 memory cycle length", c_len, e.len);
    if (e.wr) begin
      chk(!c_data_bad, "R6 data held with driver on", c_data_bad, 0);
      chk(c_data == e.data, "R6 write data", c_data, e.data);
    end
  endtask

  always @(negedge clk) begin
    logic req, strobe;
    cycles++;
    if (rst_ni) begin
      req = mem_req_o | io_req_o;
      strobe = rd_o | wr_o;
      if (rd_o && wr_o) chk(0, "R3 both strobes", 1, 0);
      if (req && !strobe) begin
        if (in_cyc) finish_cyc();
        in_cyc = 1; c_len = 1; c_io = io_req_o; c_addr = addr_o;
        c_addr_bad = 0; c_data_bad = 0; c_wr = 0;
      end else if (strobe && in_cyc) begin
        if (c_len == 1) begin
          c_wr = wr_o;
          c_data = data_o;
        end
        c_len++;
        if (addr_o != c_addr) c_addr_bad = 1;
        if (wr_o && (!data_oe_o || data_o != c_data)) c_data_bad = 1;
        if (rd_o && data_oe_o) c_data_bad = 1;
      end else if (!req && in_cyc) begin
        finish_cyc();
      end
      if (done_o) begin
        done_cnt++;
        chk(!busy_o, "R9 busy low at done", busy_o, 0);
        chk(q.size() == 0, "R7 all transfers done at done", q.size(), 0);
      end
      // wait driver: low window aligned to the sample point
      if (strobe && !prev_strobe) begin
        skip = io_req_o ? 1 : 0;
        wcnt = wlen;
      end
      if (!strobe) wait_ni <= 1'b1;
      else if (skip > 0) begin wait_ni <= 1'b1; skip--; end
      else if (wcnt > 0) begin wait_ni <= 1'b0; wcnt--; end
      else wait_ni <= 1'b1;
      prev_strobe = strobe;
    end
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_xfer(input bit sio, input bit dio, input logic [AW-1:0] sa, input logic [AW-1:0] da,
                          input bit si, input bit di, input int cnt, input bit wen, input int wl,
                          input bit poke_busy);
    int d0 = done_cnt;
    int extra = wen ? wl : 0;
    for (int i = 0; i < cnt; i++) begin
      item_t r, w;
      r.io = sio; r.wr = 0; r.addr = sa + AW'(si ? i : 0); r.data = '0;
      r.len = (sio ? 4 : 3) + extra;
      w.io = dio; w.wr = 1; w.addr = da + AW'(di ? i : 0); w.data = r.addr[7:0] ^ 8'hA5;
      w.len = (dio ? 4 : 3) + extra;
      q.push_back(r); q.push_back(w);
    end
    wlen = wl;
    @(negedge clk);
    src_io_i = sio; dst_io_i = dio; src_addr_i = sa; dst_addr_i = da;
    src_inc_i = si; dst_inc_i = di; count_i = CW'(cnt); wait_en_i = wen; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (cnt == 0) begin
      chk(done_o == 1'b1, "R10 zero count done next clock", done_o, 1);
      chk(!busy_o, "R10 zero count no busy", busy_o, 0);
    end else begin
      chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    end
    if (poke_busy) begin
      repeat (4) @(negedge clk);
      src_io_i = ~sio; src_addr_i = 16'hDEAD; count_i = 16'd7; wait_en_i = ~wen; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 3000 && done_cnt == d0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, poke_busy ? "R10 start while busy ignored" : "R9 single done pulse",
        done_cnt - d0, 1);
    chk(q.size() == 0, "R7 expected cycles consumed", q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !mem_req_o && !io_req_o && !rd_o && !wr_o && !done_o && !data_oe_o,
        "R9 reset state", {busy_o, mem_req_o, io_req_o, rd_o, wr_o, done_o, data_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 memory to memory, both incrementing
    run_xfer(0, 0, 16'h1000, 16'h2000, 1, 1, 3, 0, 0, 0);
    // R2 R8 I/O to memory, fixed source port
    run_xfer(1, 0, 16'h0040, 16'h3000, 0, 1, 2, 0, 0, 0);
    // R4 memory to I/O with two wait clocks per cycle
    run_xfer(0, 1, 16'h4010, 16'h0080, 1, 0, 2, 1, 2, 0);
    // R4 I/O to I/O one wait clock
    run_xfer(1, 1, 16'h00F0, 16'h00F8, 1, 1, 1, 1, 1, 0);
    // R5 wait input driven low but sampling disabled
    run_xfer(0, 1, 16'h5000, 16'h0090, 1, 1, 2, 0, 3, 0);
    run_xfer(1, 1, 16'h0011, 16'h0022, 0, 0, 1, 0, 2, 0);
    // R10 zero count, and start while busy
    run_xfer(0, 0, 16'h6000, 16'h7000, 1, 1, 0, 0, 0, 0);
    run_xfer(0, 0, 16'h60FE, 16'h70FF, 1, 1, 3, 1, 1, 1);
    // R8 address wrap
    run_xfer(0, 0, 16'hFFFF, 16'h0100, 1, 0, 2, 0, 0, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule